// File: doc/BRIEF.md
# Logical Device I/O Address Decoder

This block sits between the configuration register file of a multi-function I/O controller and the peripheral cores behind it. It receives the programmed base, activate, power and interrupt fields of six logical devices: a floppy controller, a parallel port, two serial ports, a keyboard controller and an auxiliary I/O byte. From each host I/O cycle it derives one chip select per device. It also produces a 16-line interrupt vector by steering each device's request onto its programmed line. For each serial port it gives the baud reference divisor.

Address decoding is purely combinational. A select rises in the same cycle as the host address and a read or write strobe. A device only responds when its enables allow it and its base, once aligned to the device's window size, falls inside a legal I/O window. The auxiliary device is the only one with storage: a single 8-bit register that the host can write through its select and that is always visible on a read-data output. The control and status pins are plain levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `ldev_io_decode`

## Requirements
- R1: The floppy and serial ports each decode an 8-byte window at base AND 0xFFF8. The parallel port decodes a 4-byte window at base AND 0xFFFC. The auxiliary device decodes the single address equal to its base. Low base bits that the mask removes are ignored.
- R2: A device produces no select unless its aligned base is at least 0x0100 and no more than a per-device ceiling: 0x0FF8 for floppy and serial, 0x0FFC for parallel, 0x0FFF for auxiliary.
- R3: Floppy, parallel, serial 0 and serial 1 need both their activate input and their bit of `glob_pwr` set. The bits are: bit 0 floppy, bit 3 parallel, bit 4 serial 0, bit 5 serial 1. With either one clear, the select stays low.
- R4: The keyboard select is high only for address 0x0060 while `kbd_act` is set. Its other inputs play no part in that decode.
- R5: Every select is low unless `io_rd` or `io_wr` is high. A select follows the address and strobe in the same cycle.
- R6: The auxiliary register resets to 0x00. A cycle with `aux_cs` and `io_wr` loads `io_wdata`, which appears on `aux_rdata` after that clock edge.
- R7: `ser_div_x8[i]` gives eight times the divisor that `ser_mode[i]` bits 1:0 select: 00 gives 104 (÷13), 01 gives 96 (÷12), 10 gives 8 (÷1), 11 gives 13 (÷1.625).
- R8: A raised request from an enabled device drives `irq_out` bit N, where N is the device's IRQ number. The enable is R3's condition, or `kbd_act` for the keyboard. An IRQ number of 16 or more drives no line. A request from a disabled device has no effect.
- R9: When `ser_mode[0]` bit 7 is set, both serial requests go to serial 0's IRQ number, and serial 1's own number drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the auxiliary register |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| glob_pwr | input | 8 | Global power byte (bits 0,3,4,5 used) |
| fdc_act | input | 1 | Floppy activate |
| fdc_base | input | 16 | Floppy base (high byte, low byte) |
| fdc_irq_num | input | 8 | Floppy IRQ number |
| fdc_irq_req | input | 1 | Floppy interrupt request |
| lpt_act | input | 1 | Parallel activate |
| lpt_base | input | 16 | Parallel base |
| lpt_irq_num | input | 8 | Parallel IRQ number |
| lpt_irq_req | input | 1 | Parallel interrupt request |
| ser_act | input | 2 | Serial activate per port |
| ser_base | input | 2x16 | Serial bases |
| ser_irq_num | input | 2x8 | Serial IRQ numbers |
| ser_irq_req | input | 2 | Serial interrupt requests |
| ser_mode | input | 2x8 | Serial mode bytes (clock select, share bit) |
| kbd_act | input | 1 | Keyboard activate |
| kbd_irq_num | input | 8 | Keyboard IRQ number |
| kbd_irq_req | input | 1 | Keyboard interrupt request |
| aux_act | input | 1 | Auxiliary activate |
| aux_base | input | 16 | Auxiliary base |
| fdc_cs | output | 1 | Floppy select |
| lpt_cs | output | 1 | Parallel select |
| ser_cs | output | 2 | Serial selects |
| kbd_cs | output | 1 | Keyboard select |
| aux_cs | output | 1 | Auxiliary select |
| aux_rdata | output | 8 | Auxiliary register contents |
| ser_div_x8 | output | 2x8 | Eight times each serial divisor |
| irq_out | output | 16 | Interrupt line vector |

## Verification
Address decode and interrupt steering are independent paths, and they can be active in the same cycle. The sharp case is a host access to serial port 1 while both serial requests are raised in shared mode. The bench drives exactly that: share bit on, both requests high, a read at an address inside serial 1's window. In one sample it expects the select vector to show only serial 1 and the interrupt vector to show only serial 0's line. A select that leaked into routing, or routing that ignored the share bit, would spoil one of the two compares.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  localparam logic [15:0] ALIGN8_MASK  = 16'hFFF8;
  localparam logic [15:0] ALIGN4_MASK  = 16'hFFFC;
  localparam logic [15:0] ALIGN1_MASK  = 16'hFFFF;
  localparam logic [15:0] WIN_FLOOR    = 16'h0100;
  localparam logic [15:0] CEIL_8BYTE   = 16'h0FF8;
  localparam logic [15:0] CEIL_4BYTE   = 16'h0FFC;
  localparam logic [15:0] CEIL_1BYTE   = 16'h0FFF;
  localparam logic [15:0] KBD_ADDR     = 16'h0060;

  localparam int PWR_FDC_BIT  = 0;
  localparam int PWR_LPT_BIT  = 3;
  localparam int PWR_SER0_BIT = 4;
  localparam int SHARE_BIT    = 7;

  typedef enum logic [1:0] {
    CLK_DIV13  = 2'b00,
    CLK_DIV12  = 2'b01,
    CLK_DIV1   = 2'b10,
    CLK_DIV1P6 = 2'b11
  } clk_sel_e;

  function automatic logic [7:0] div_times8(input clk_sel_e sel);
    case (sel)
      CLK_DIV13: return 8'd104;
      CLK_DIV12: return 8'd96;
      CLK_DIV1:  return 8'd8;
      default:   return 8'd13;
    endcase
  endfunction
endpackage

// File: rtl/ldec_window.sv
module ldec_window #(
  parameter int AW = 16,
  parameter logic [AW-1:0] MASK  = '1,
  parameter logic [AW-1:0] FLOOR = '0,
  parameter logic [AW-1:0] CEIL  = '1
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic          en,
  input  logic          strb,
  output logic          cs
);
  logic [AW-1:0] aligned;
  logic          legal;
  logic          hit;

  always_comb begin
    aligned = base & MASK;
    legal   = (aligned >= FLOOR) && (aligned <= CEIL);
    hit     = ((addr & MASK) == aligned);
    cs      = en && strb && legal && hit;
  end
endmodule

// File: rtl/ldec_irq_route.sv
module ldec_irq_route #(
  parameter int NSRC  = 5,
  parameter int NUM_W = 8,
  parameter int LINES = 16
) (
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0]            en,
  input  logic [NSRC-1:0][NUM_W-1:0] num,
  output logic [LINES-1:0]           lines
);
  always_comb begin
    lines = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int l = 0; l < LINES; l++) begin
        if (req[s] && en[s] && (num[s] == NUM_W'(l)))
          lines[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldec_aux_reg.sv
module ldec_aux_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (we)
      q <= wdata;
  end
endmodule

// File: rtl/ldev_io_decode.sv
module ldev_io_decode
  import ldec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SER   = 2,
  parameter int IRQ_NUM_W = 8,
  parameter int IRQ_LINES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 io_addr,
  input  logic                              io_rd,
  input  logic                              io_wr,
  input  logic [DATA_W-1:0]                 io_wdata,
  input  logic [7:0]                        glob_pwr,
  input  logic                              fdc_act,
  input  logic [ADDR_W-1:0]                 fdc_base,
  input  logic [IRQ_NUM_W-1:0]              fdc_irq_num,
  input  logic                              fdc_irq_req,
  input  logic                              lpt_act,
  input  logic [ADDR_W-1:0]                 lpt_base,
  input  logic [IRQ_NUM_W-1:0]              lpt_irq_num,
  input  logic                              lpt_irq_req,
  input  logic [NUM_SER-1:0]                ser_act,
  input  logic [NUM_SER-1:0][ADDR_W-1:0]    ser_base,
  input  logic [NUM_SER-1:0][IRQ_NUM_W-1:0] ser_irq_num,
  input  logic [NUM_SER-1:0]                ser_irq_req,
  input  logic [NUM_SER-1:0][7:0]           ser_mode,
  input  logic                              kbd_act,
  input  logic [IRQ_NUM_W-1:0]              kbd_irq_num,
  input  logic                              kbd_irq_req,
  input  logic                              aux_act,
  input  logic [ADDR_W-1:0]                 aux_base,
  output logic                              fdc_cs,
  output logic                              lpt_cs,
  output logic [NUM_SER-1:0]                ser_cs,
  output logic                              kbd_cs,
  output logic                              aux_cs,
  output logic [DATA_W-1:0]                 aux_rdata,
  output logic [NUM_SER-1:0][7:0]           ser_div_x8,
  output logic [IRQ_LINES-1:0]              irq_out
);
  localparam int NSRC    = NUM_SER + 3;
  localparam int SRC_FDC = 0;
  localparam int SRC_LPT = 1;
  localparam int SRC_SER = 2;
  localparam int SRC_KBD = NUM_SER + 2;

  logic               strb;
  logic               fdc_en;
  logic               lpt_en;
  logic [NUM_SER-1:0] ser_en;
  logic               share;

  assign strb   = io_rd | io_wr;
  assign fdc_en = glob_pwr[PWR_FDC_BIT] & fdc_act;
  assign lpt_en = glob_pwr[PWR_LPT_BIT] & lpt_act;
  assign share  = ser_mode[0][SHARE_BIT];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{glob_pwr[2:1], glob_pwr[7:6], ser_mode};

  ldec_window #(
    .AW(ADDR_W), .MASK(ADDR_W'(ALIGN8_MASK)),
    .FLOOR(ADDR_W'(WIN_FLOOR)), .CEIL(ADDR_W'(CEIL_8BYTE))
  ) u_fdc_win (
    .addr(io_addr), .base(fdc_base), .en(fdc_en), .strb(strb), .cs(fdc_cs)
  );

  ldec_window #(
    .AW(ADDR_W), .MASK(ADDR_W'(ALIGN4_MASK)),
    .FLOOR(ADDR_W'(WIN_FLOOR)), .CEIL(ADDR_W'(CEIL_4BYTE))
  ) u_lpt_win (
    .addr(io_addr), .base(lpt_base), .en(lpt_en), .strb(strb), .cs(lpt_cs)
  );

  ldec_window #(
    .AW(ADDR_W), .MASK(ADDR_W'(ALIGN1_MASK)),
    .FLOOR(ADDR_W'(WIN_FLOOR)), .CEIL(ADDR_W'(CEIL_1BYTE))
  ) u_aux_win (
    .addr(io_addr), .base(aux_base), .en(aux_act), .strb(strb), .cs(aux_cs)
  );

  // Keyboard: fixed address, no base and no range check.
  assign kbd_cs = kbd_act && strb && (io_addr == ADDR_W'(KBD_ADDR));

  logic [NSRC-1:0]                req_vec;
  logic [NSRC-1:0]                en_vec;
  logic [NSRC-1:0][IRQ_NUM_W-1:0] num_vec;

  assign req_vec[SRC_FDC] = fdc_irq_req;
  assign en_vec[SRC_FDC]  = fdc_en;
  assign num_vec[SRC_FDC] = fdc_irq_num;
  assign req_vec[SRC_LPT] = lpt_irq_req;
  assign en_vec[SRC_LPT]  = lpt_en;
  assign num_vec[SRC_LPT] = lpt_irq_num;
  assign req_vec[SRC_KBD] = kbd_irq_req;
  assign en_vec[SRC_KBD]  = kbd_act;
  assign num_vec[SRC_KBD] = kbd_irq_num;

  for (genvar i = 0; i < NUM_SER; i++) begin : g_ser
    assign ser_en[i] = glob_pwr[PWR_SER0_BIT + i] & ser_act[i];

    ldec_window #(
      .AW(ADDR_W), .MASK(ADDR_W'(ALIGN8_MASK)),
      .FLOOR(ADDR_W'(WIN_FLOOR)), .CEIL(ADDR_W'(CEIL_8BYTE))
    ) u_ser_win (
      .addr(io_addr), .base(ser_base[i]), .en(ser_en[i]), .strb(strb),
      .cs(ser_cs[i])
    );

    assign ser_div_x8[i] = div_times8(clk_sel_e'(ser_mode[i][1:0]));

    assign req_vec[SRC_SER + i] = ser_irq_req[i];
    assign en_vec[SRC_SER + i]  = ser_en[i];
    assign num_vec[SRC_SER + i] = share ? ser_irq_num[0] : ser_irq_num[i];
  end

  ldec_irq_route #(
    .NSRC(NSRC), .NUM_W(IRQ_NUM_W), .LINES(IRQ_LINES)
  ) u_irq (
    .req(req_vec), .en(en_vec), .num(num_vec), .lines(irq_out)
  );

  ldec_aux_reg #(.DW(DATA_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .we(aux_cs & io_wr), .wdata(io_wdata),
    .q(aux_rdata)
  );
endmodule

// File: rtl/ldec_checks.sv
module ldec_checks (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     io_addr,
  input logic            io_rd,
  input logic            io_wr,
  input logic [7:0]      io_wdata,
  input logic [7:0]      glob_pwr,
  input logic            fdc_act,
  input logic [15:0]     lpt_base,
  input logic [1:0]      ser_act,
  input logic [1:0][7:0] ser_irq_num,
  input logic [1:0]      ser_irq_req,
  input logic [1:0][7:0] ser_mode,
  input logic            fdc_cs,
  input logic            lpt_cs,
  input logic [1:0]      ser_cs,
  input logic            kbd_cs,
  input logic            aux_cs,
  input logic [7:0]      aux_rdata,
  input logic [1:0][7:0] ser_div_x8,
  input logic [15:0]     irq_out
);
  // R5
  sel_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdc_cs || lpt_cs || (|ser_cs) || kbd_cs || aux_cs) |-> (io_rd || io_wr));

  // R3
  fdc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_cs |-> (glob_pwr[0] && fdc_act));

  // R3
  ser0_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs[0] |-> (glob_pwr[4] && ser_act[0]));

  // R2
  lpt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_cs |-> (((lpt_base & 16'hFFFC) >= 16'h0100) &&
                ((lpt_base & 16'hFFFC) <= 16'h0FFC)));

  // R4
  kbd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_cs |-> (io_addr == 16'h0060));

  // R6
  aux_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_cs && io_wr) |=> (aux_rdata == $past(io_wdata)));

  // R7
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode[0][1:0] == 2'b10) |-> (ser_div_x8[0] == 8'd8));

  // R9
  share_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode[0][7] && ser_irq_req[1] && glob_pwr[5] && ser_act[1] &&
     (ser_irq_num[0] < 8'd16)) |-> irq_out[ser_irq_num[0][3:0]]);
endmodule

bind ldev_io_decode ldec_checks u_checks (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .glob_pwr(glob_pwr), .fdc_act(fdc_act),
  .lpt_base(lpt_base), .ser_act(ser_act), .ser_irq_num(ser_irq_num),
  .ser_irq_req(ser_irq_req), .ser_mode(ser_mode), .fdc_cs(fdc_cs),
  .lpt_cs(lpt_cs), .ser_cs(ser_cs), .kbd_cs(kbd_cs), .aux_cs(aux_cs),
  .aux_rdata(aux_rdata), .ser_div_x8(ser_div_x8), .irq_out(irq_out)
);

// File: tb/ldev_io_decode_test.sv
module ldev_io_decode_test;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     io_addr;
  logic            io_rd, io_wr;
  logic [7:0]      io_wdata;
  logic [7:0]      glob_pwr;
  logic            fdc_act, lpt_act, kbd_act, aux_act;
  logic [15:0]     fdc_base, lpt_base, aux_base;
  logic [7:0]      fdc_irq_num, lpt_irq_num, kbd_irq_num;
  logic            fdc_irq_req, lpt_irq_req, kbd_irq_req;
  logic [1:0]      ser_act, ser_irq_req;
  logic [1:0][15:0] ser_base;
  logic [1:0][7:0] ser_irq_num, ser_mode;
  logic            fdc_cs, lpt_cs, kbd_cs, aux_cs;
  logic [1:0]      ser_cs;
  logic [7:0]      aux_rdata;
  logic [1:0][7:0] ser_div_x8;
  logic [15:0]     irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldev_io_decode uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .glob_pwr(glob_pwr),
    .fdc_act(fdc_act), .fdc_base(fdc_base), .fdc_irq_num(fdc_irq_num),
    .fdc_irq_req(fdc_irq_req),
    .lpt_act(lpt_act), .lpt_base(lpt_base), .lpt_irq_num(lpt_irq_num),
    .lpt_irq_req(lpt_irq_req),
    .ser_act(ser_act), .ser_base(ser_base), .ser_irq_num(ser_irq_num),
    .ser_irq_req(ser_irq_req), .ser_mode(ser_mode),
    .kbd_act(kbd_act), .kbd_irq_num(kbd_irq_num), .kbd_irq_req(kbd_irq_req),
    .aux_act(aux_act), .aux_base(aux_base),
    .fdc_cs(fdc_cs), .lpt_cs(lpt_cs), .ser_cs(ser_cs), .kbd_cs(kbd_cs),
    .aux_cs(aux_cs), .aux_rdata(aux_rdata), .ser_div_x8(ser_div_x8),
    .irq_out(irq_out)
  );

  // kinds: 0 select vector {aux,kbd,ser1,ser0,lpt,fdc}, 1 irq_out,
  //        2 {div1,div0}, 3 aux_rdata
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t queue_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return {26'd0, aux_cs, kbd_cs, ser_cs[1], ser_cs[0], lpt_cs, fdc_cs};
      1: return {16'd0, irq_out};
      2: return {16'd0, ser_div_x8[1], ser_div_x8[0]};
      default: return {24'd0, aux_rdata};
    endcase
  endfunction

  task automatic expect_item(input int kind, input logic [31:0] exp,
                             input string req);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    queue_q.push_back(it);
  endtask

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (queue_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = queue_q.pop_front();
        got = observe(it.kind);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind,
                   got, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_defaults();
    io_addr = 16'h0000; io_rd = 0; io_wr = 0; io_wdata = 8'h00;
    glob_pwr = 8'h39;
    fdc_act = 1; fdc_base = 16'h03F0; fdc_irq_num = 8'd6; fdc_irq_req = 0;
    lpt_act = 1; lpt_base = 16'h0378; lpt_irq_num = 8'd7; lpt_irq_req = 0;
    ser_act = 2'b11; ser_base[0] = 16'h03F8; ser_base[1] = 16'h02F8;
    ser_irq_num[0] = 8'd4; ser_irq_num[1] = 8'd3; ser_irq_req = 2'b00;
    ser_mode[0] = 8'h00; ser_mode[1] = 8'h00;
    kbd_act = 1; kbd_irq_num = 8'd1; kbd_irq_req = 0;
    aux_act = 1; aux_base = 16'h0200;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_defaults();
    tick();
    expect_item(3, 32'h00, "R6 reset value");
    expect_item(0, 32'h00, "R5 idle selects");
    tick();
    rst_n = 1;

    // R1 windows
    tick(); io_rd = 1; io_addr = 16'h03F5; expect_item(0, 32'h01, "R1 fdc");
    tick(); io_addr = 16'h03F8; expect_item(0, 32'h04, "R1 ser0");
    tick(); io_addr = 16'h037B; expect_item(0, 32'h02, "R1 lpt top");
    tick(); io_addr = 16'h037C; expect_item(0, 32'h00, "R1 lpt past end");
    tick(); io_addr = 16'h02FF; expect_item(0, 32'h08, "R1 ser1");
    // R5 no strobe
    tick(); io_rd = 0; io_addr = 16'h03F5; expect_item(0, 32'h00, "R5 no strobe");
    // R4 keyboard
    tick(); io_rd = 1; io_addr = 16'h0060; expect_item(0, 32'h10, "R4 kbd");
    tick(); io_addr = 16'h0064; expect_item(0, 32'h00, "R4 kbd other addr");
    tick(); kbd_act = 0; io_addr = 16'h0060; expect_item(0, 32'h00, "R4 kbd off");
    tick(); kbd_act = 1;
    // R6 auxiliary register
    tick(); io_rd = 0; io_wr = 1; io_addr = 16'h0200; io_wdata = 8'hA5;
    expect_item(0, 32'h20, "R6 aux select on write");
    tick(); io_wr = 0; io_rd = 1; io_addr = 16'h0000; io_wdata = 8'h00;
    expect_item(3, 32'hA5, "R6 aux stored");
    expect_item(0, 32'h00, "R5 unmapped address");
    tick(); io_addr = 16'h0201; expect_item(0, 32'h00, "R1 aux single byte");
    // R3 enables
    tick(); glob_pwr = 8'h38; io_addr = 16'h03F0; expect_item(0, 32'h00, "R3 fdc power off");
    tick(); glob_pwr = 8'h39; fdc_act = 0; expect_item(0, 32'h00, "R3 fdc inactive");
    tick(); fdc_act = 1; expect_item(0, 32'h01, "R3 fdc both on");
    tick(); glob_pwr = 8'h29; io_addr = 16'h03F8; expect_item(0, 32'h00, "R3 ser0 power off");
    tick(); io_addr = 16'h02F8; expect_item(0, 32'h08, "R3 ser1 unaffected");
    tick(); glob_pwr = 8'h39;
    // R2 legal range
    tick(); fdc_base = 16'h00F0; io_addr = 16'h00F0; expect_item(0, 32'h00, "R2 below floor");
    tick(); fdc_base = 16'h1000; io_addr = 16'h1000; expect_item(0, 32'h00, "R2 above ceiling");
    tick(); fdc_base = 16'h0FF8; io_addr = 16'h0FFF; expect_item(0, 32'h01, "R2 fdc at ceiling");
    tick(); fdc_base = 16'h03F0; lpt_base = 16'h0FFC; io_addr = 16'h0FFE;
    expect_item(0, 32'h02, "R2 lpt at ceiling");
    tick(); lpt_base = 16'h0378; aux_base = 16'h0FFF; io_addr = 16'h0FFF;
    expect_item(0, 32'h20, "R2 aux at ceiling");
    tick(); aux_base = 16'h00FF; io_addr = 16'h00FF; expect_item(0, 32'h00, "R2 aux below floor");
    tick(); aux_base = 16'h0200; fdc_base = 16'h03F3; io_addr = 16'h03F0;
    expect_item(0, 32'h01, "R1 base low bits masked");
    tick(); fdc_base = 16'h03F0; io_rd = 0;
    // R7 divisors
    tick(); ser_mode[0] = 8'h00; ser_mode[1] = 8'h01;
    expect_item(2, 32'h6068, "R7 div13 div12");
    tick(); ser_mode[0] = 8'h02; ser_mode[1] = 8'h03;
    expect_item(2, 32'h0D08, "R7 div1 div1.625");
    tick(); ser_mode[0] = 8'h00; ser_mode[1] = 8'h00;
    // R8 / R9 interrupt routing
    tick(); fdc_irq_req = 1; expect_item(1, 32'h0040, "R8 fdc line 6");
    tick(); fdc_irq_req = 0; lpt_irq_req = 1; expect_item(1, 32'h0080, "R8 lpt line 7");
    tick(); lpt_irq_num = 8'h20; expect_item(1, 32'h0000, "R8 number above 15");
    tick(); lpt_irq_req = 0; lpt_irq_num = 8'd7; ser_irq_req = 2'b11;
    expect_item(1, 32'h0018, "R8 serial own lines");
    tick(); ser_mode[0] = 8'h80; expect_item(1, 32'h0010, "R9 shared both");
    tick(); ser_irq_req = 2'b10; expect_item(1, 32'h0010, "R9 ser1 on shared line");
    tick(); ser_mode[0] = 8'h00; expect_item(1, 32'h0008, "R8 ser1 own line");
    tick(); ser_irq_req = 2'b00; kbd_irq_req = 1; expect_item(1, 32'h0002, "R8 kbd line 1");
    tick(); kbd_irq_req = 0; glob_pwr = 8'h38; fdc_irq_req = 1;
    expect_item(1, 32'h0000, "R8 disabled device");
    // Same cycle: select plus shared routing
    tick(); glob_pwr = 8'h39; fdc_irq_req = 0; ser_mode[0] = 8'h80;
    ser_irq_req = 2'b11; io_rd = 1; io_addr = 16'h02F9;
    expect_item(0, 32'h08, "R1 ser1 select with irq");
    expect_item(1, 32'h0010, "R9 shared irq with select");
    tick();
    set_defaults();
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule